// File: doc/BRIEF.md
# Asynchronous serial transmitter with host-supplied extra bit

This block turns one host write into one asynchronous serial frame. The frame holds a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional extra bit, then one high stop bit. The extra bit is whatever value the host wrote. The block never computes parity, so the extra bit can serve as an address/data marker on a multi-drop 9-bit network. Every bit lasts 16 ticks of an external oversampling baud enable. A busy flag covers the whole frame. A write that arrives while a frame is on the line is dropped.

The block also handles two modem-control signals. The request-to-send control bit drives its output pin inverted, so a control value of 0 gives a high pin. The clear-to-send pin is synchronised and reported as a status bit, also inverted, so a high pin reads as 0. The register decoder and the baud-rate generator sit outside the block. Word length and extra-bit enable are sampled at the moment a write is accepted.

Top module: `uart_xbit_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `rts_pin` is 1 and `cts_stat` is 0 while `cts_pin` is high. Whenever `busy` is 0, `txd` is 1.
- R2: An accepted frame starts with a 0 start bit, sends data least significant bit first, and ends with exactly one 1 stop bit. Each bit holds `txd` for exactly 16 consumed `baud_tick` pulses.
- R3: With `cfg_len7` = 0 the frame carries `wr_data[7:0]`. With `cfg_len7` = 1 it carries `wr_data[6:0]`, and `wr_data[7]` is never sent.
- R4: With `cfg_xen` = 1, one bit equal to `wr_xbit` follows the last data bit. Its value does not depend on the data contents.
- R5: With `cfg_xen` = 0, no extra bit is sent and the value of `wr_xbit` has no effect on the line.
- R6: `rts_pin` equals the inverse of `cfg_rts` as sampled at the previous clock edge. It is high during and right after reset.
- R7: `cts_stat` equals the inverse of `cts_pin`, delayed by a two-flop synchroniser. A change on the pin shows on the status two clock edges later.
- R8: A write is accepted when `wr_stb` is 1 and `busy` is 0. `busy` rises on the next edge and falls on the edge that consumes the stop bit's 16th tick. A write made while `busy` is 1 is ignored.
- R9: Word length, extra-bit enable, data and extra bit are captured when the write is accepted. Changing those inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_xen | input | 1 | 1 appends the host-written extra bit |
| cfg_rts | input | 1 | Request-to-send control bit (pin is its inverse) |
| wr_stb | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Data byte to send |
| wr_xbit | input | 1 | Extra bit to send after the data |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| rts_pin | output | 1 | Request-to-send pin |
| cts_stat | output | 1 | Clear-to-send status, inverse of the synchronised pin |

## Verification
The hardest case to reach from the ports is a second write, together with new configuration values, arriving in the middle of a frame that is already on the line. The stimulus raises the strobe with inverted data, inverted extra bit and flipped length and enable settings during the fourth bit of a frame. It then checks every tick of the remaining bits against the frame captured at the original write. The main sweep covers all four length and enable combinations, both extra-bit values and a set of data patterns. That sweep runs at one tick per clock, and a slower tick rate is used to expose any counting done per clock instead of per tick.

// File: rtl/uxt_pkg.sv
package uxt_pkg;
  typedef struct packed {
    logic len7;
    logic xen;
  } uxt_cfg_t;

  function automatic int uxt_data_bits(input int data_w, input logic len7);
    return len7 ? data_w - 1 : data_w;
  endfunction
endpackage

// File: rtl/uxt_rst_sync.sv
module uxt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/uxt_modem.sv
module uxt_modem #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rts,
  input  logic cts_pin,
  output logic rts_pin,
  output logic cts_stat
);
  logic rts_q;
  logic rts_d;
  logic [SYNC_STAGES-1:0] cts_q;
  logic [SYNC_STAGES-1:0] cts_d;

  always_comb begin
    rts_d = cfg_rts;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_cts
      if (s == 0) begin : g_first
        always_comb cts_d[s] = cts_pin;
      end else begin : g_next
        always_comb cts_d[s] = cts_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q <= 1'b0;
      cts_q <= '1;
    end else begin
      rts_q <= rts_d;
      cts_q <= cts_d;
    end
  end

  assign rts_pin  = ~rts_q;
  assign cts_stat = ~cts_q[SYNC_STAGES-1];

  assert_rts_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rts_pin == !$past(cfg_rts)));
endmodule

// File: rtl/uxt_bit_timer.sv
module uxt_bit_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic baud_tick,
  output logic bit_done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          tick_en;

  assign tick_en  = run & baud_tick;
  assign bit_done = tick_en & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (tick_en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_bit_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> (cnt_q == '0));
endmodule

// File: rtl/uxt_frame_shift.sv
module uxt_frame_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [DATA_W-1:0] data,
  input  logic              xbit,
  input  uxt_pkg::uxt_cfg_t cfg,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d, frame_vec;
  logic [CNT_W-1:0]   left_q, left_d, frame_len;
  int                 nd;

  always_comb begin
    nd        = uxt_pkg::uxt_data_bits(DATA_W, cfg.len7);
    frame_vec = '1;
    frame_vec[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (i < nd)                 frame_vec[1+i] = data[i];
      else if (i == nd && cfg.xen) frame_vec[1+i] = xbit;
    end
    frame_len = CNT_W'(nd + int'(cfg.xen) + 2);
  end

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = frame_vec;
      left_d = frame_len;
    end else if (advance && left_q != '0) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign busy = (left_q != '0);
  assign txd  = sh_q[0];

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));
endmodule

// File: rtl/uart_xbit_tx.sv
module uart_xbit_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_len7,
  input  logic              cfg_xen,
  input  logic              cfg_rts,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_xbit,
  input  logic              cts_pin,
  output logic              txd,
  output logic              busy,
  output logic              rts_pin,
  output logic              cts_stat
);
  logic              rst_int_n;
  logic              accept;
  logic              bit_done;
  uxt_pkg::uxt_cfg_t cfg;

  assign cfg.len7 = cfg_len7;
  assign cfg.xen  = cfg_xen;
  assign accept   = wr_stb & ~busy;

  uxt_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  uxt_bit_timer #(.TICKS(TICKS_PER_BIT)) i_timer (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .clear(accept),
    .baud_tick(baud_tick), .bit_done(bit_done)
  );

  uxt_frame_shift #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .advance(bit_done),
    .data(wr_data), .xbit(wr_xbit), .cfg(cfg), .txd(txd), .busy(busy)
  );

  uxt_modem #(.SYNC_STAGES(SYNC_STAGES)) i_modem (
    .clk(clk), .rst_n(rst_int_n), .cfg_rts(cfg_rts), .cts_pin(cts_pin),
    .rts_pin(rts_pin), .cts_stat(cts_stat)
  );

  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && wr_stb && !bit_done) |=> busy);
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> busy);
endmodule

// File: tb/test_uart_xbit_tx.sv
module test_uart_xbit_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_len7 = 1'b0, cfg_xen = 1'b0, cfg_rts = 1'b0;
  logic       wr_stb = 1'b0, wr_xbit = 1'b0, cts_pin = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       txd, busy, rts_pin, cts_stat;

  int total = 0, bad = 0, tick_gap = 1, tick_div = 0, cycles = 0;
  bit done = 1'b0;

  uart_xbit_tx i_uart_xbit_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len7(cfg_len7),
    .cfg_xen(cfg_xen), .cfg_rts(cfg_rts), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_xbit(wr_xbit), .cts_pin(cts_pin), .txd(txd), .busy(busy),
    .rts_pin(rts_pin), .cts_stat(cts_stat)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tick_div >= tick_gap - 1) begin
      tick_div  <= 0;
      baud_tick <= 1'b1;
    end else begin
      tick_div  <= tick_div + 1;
      baud_tick <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input logic x, input logic l7,
                           input logic xe, input bit disturb);
    logic [10:0] exp;
    int nd, nb;
    string tag;
    while (busy) @(negedge clk);
    nd = l7 ? 7 : 8;
    nb = nd + (xe ? 1 : 0) + 2;
    exp = '1;
    exp[0] = 1'b0;
    for (int i = 0; i < nd; i++) exp[1+i] = d[i];
    if (xe) exp[1+nd] = x;
    tag = $sformatf("R2 R3 %s%s", xe ? "R4" : "R5", disturb ? " R8 R9" : "");
    cfg_len7 = l7; cfg_xen = xe; wr_data = d; wr_xbit = x; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(busy == 1'b1, "R8 busy after write", {31'd0, busy}, 32'd1);
    for (int k = 0; k < nb; k++) begin
      for (int t = 0; t < 16; t++) begin
        while (!baud_tick) @(negedge clk);
        chk(busy && txd == exp[k], $sformatf("%s bit%0d tick%0d", tag, k, t),
            {30'd0, busy, txd}, {30'd0, 1'b1, exp[k]});
        if (disturb && k == 3 && t == 5) begin
          wr_stb = 1'b1; wr_data = ~d; wr_xbit = ~x; cfg_len7 = ~l7; cfg_xen = ~xe;
        end
        @(negedge clk);
        wr_stb = 1'b0;
      end
    end
    chk(!busy && txd, "R8 R1 idle after stop", {30'd0, busy, txd}, 32'd1);
  endtask

  initial begin
    logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h80, 8'h7F, 8'h01, 8'hA5};
    repeat (4) @(negedge clk);
    chk(txd && !busy && rts_pin && !cts_stat, "R1 R6 in reset",
        {28'd0, txd, busy, rts_pin, cts_stat}, 32'hA);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd && !busy && rts_pin && !cts_stat, "R1 R6 after reset",
        {28'd0, txd, busy, rts_pin, cts_stat}, 32'hA);

    cfg_rts = 1'b1;
    @(negedge clk);
    chk(rts_pin == 1'b0, "R6 rts asserted", {31'd0, rts_pin}, 32'd0);
    cfg_rts = 1'b0;
    @(negedge clk);
    chk(rts_pin == 1'b1, "R6 rts released", {31'd0, rts_pin}, 32'd1);

    cts_pin = 1'b0;
    @(negedge clk);
    chk(cts_stat == 1'b0, "R7 cts first stage", {31'd0, cts_stat}, 32'd0);
    @(negedge clk);
    chk(cts_stat == 1'b1, "R7 cts low seen", {31'd0, cts_stat}, 32'd1);
    cts_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk(cts_stat == 1'b0, "R7 cts high seen", {31'd0, cts_stat}, 32'd0);

    tick_gap = 1;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 8; p++)
        for (int xv = 0; xv < 2; xv++)
          run_frame(pats[p], xv[0], c[1], c[0], 1'b0);

    for (int c = 0; c < 4; c++) run_frame(8'hC6, c[0], c[1], c[0], 1'b1);

    tick_gap = 3;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 4; c++) run_frame(8'h93, ~c[0], c[0], c[1], c[0]);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule